// File: doc/BRIEF.md
# Tagged FIFO Synchronization Cell

This block is a single first-in first-out cell that lets threads exchange data and synchronize with each other. It holds a small ring of 64-bit entries together with a tag: an empty flag, a full flag, a trap flag, a constant FIFO-mode bit, the current entry count and a code for the depth. Each request picks one of four views. A raw view reads the head entry or patches the newest entry without moving any pointer. A tag view reads the whole tag as one word or loads its flags. Two queue views push on a write and pop on a read: one of them waits when it cannot proceed and the other never does.

A request in the waiting queue view that meets an empty cell on a read, or a cell flagged full on a write, completes nothing. Its requester ID is added to a waiter bitmask and the cell answers with a stall response. The next queue-view access that gets past the waiting check drives a one-cycle wake pulse that carries the whole waiter mask, and the mask is then cleared. The requesters retry after that. Every request is answered exactly one clock cycle after it is accepted, and the cell accepts one request per cycle. The depth must be a power of two.

Top module: `tagged_fifo_cell`

## Requirements
- R1: After reset the tag reads back as 0x30020001 for the default depth of 8. This means empty=1, full=0, trap=0, FIFO-mode=1, count=0 and depth code 3. Neither a response nor a wake pulse is present after reset.
- R2: A tag-view read returns a word with these fields: empty at bit 0, full at bit 1, trap at bit 16, FIFO-mode (always 1) at bit 17, the entry count in bits 27:18, and log2 of the depth in bits 31:28. All other bits are zero.
- R3: A tag-view write loads trap from bit 16, empty from bit 0 and full from bit 1 of the write data, and its response data is zero. If the loaded empty bit is 1, the entry count becomes zero.
- R4: A queue-view read always clears the full flag. A waiting-view read (view code 2) that finds empty set pops nothing and answers with stall=1 and zero data. It also records its requester ID in the waiter mask.
- R5: A queue-view read that proceeds returns the oldest entry and advances the read position modulo the depth, decrementing the count. If the count was zero it returns zero instead. Empty becomes 1 whenever the count afterwards is zero. A non-waiting read (view code 3) never stalls.
- R6: A queue-view write always clears the empty flag. A waiting-view write that finds full set stores nothing and answers with stall=1. It also records its requester ID in the waiter mask.
- R7: A queue-view write that proceeds stores its data at (read position + count) modulo the depth and increments the count, but only when the count is below the depth. Otherwise the data is dropped. Full becomes 1 when the count afterwards equals the depth.
- R8: A queue-view access that gets past the waiting check, while the waiter mask is nonzero, raises wake_valid together with its response, with wake_mask equal to the recorded mask. The mask is then cleared. No wake is produced while the mask is zero.
- R9: A raw-view read (view code 0) returns the head entry without changing the tag. A raw-view write replaces the most recently pushed entry when the count is nonzero, and is ignored when the count is zero.
- R10: Each accepted request produces exactly one response, with resp_valid high, in the cycle after the edge that accepted it. Requests may come back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_view | input | 2 | 0 raw, 1 tag, 2 waiting queue, 3 non-waiting queue |
| req_wr | input | 1 | 1 write, 0 read |
| req_id | input | 3 | Requester ID (bit index in the waiter mask) |
| req_wdata | input | 64 | Write data |
| resp_valid | output | 1 | Response present |
| resp_stall | output | 1 | Request could not complete and was recorded as a waiter |
| resp_rdata | output | 64 | Read data (zero for writes and stalls) |
| wake_valid | output | 1 | One-cycle wake pulse |
| wake_mask | output | 8 | Waiters released by this pulse |

## Verification
A request driven on a falling edge is taken at the next rising edge. Its response and any wake pulse are registered at that same edge, so both are due one cycle after the stimulus. The bench computes each expected response and wake from its own model of the tag and ring when it drives a request, and queues that expectation. A monitor samples the outputs at every falling edge and pops one expectation for each resp_valid. Because requests are issued back to back, any extra, missing or late response shows up as a mismatch against the queued order.

// File: rtl/tfc_pkg.sv
package tfc_pkg;

  typedef enum logic [1:0] {
    VIEW_RAW  = 2'd0,
    VIEW_TAG  = 2'd1,
    VIEW_WAIT = 2'd2,
    VIEW_POLL = 2'd3
  } view_e;

  // tag word field positions (decoded by software)
  localparam int unsigned BIT_EMPTY  = 0;
  localparam int unsigned BIT_FULL   = 1;
  localparam int unsigned BIT_TRAP   = 16;
  localparam int unsigned BIT_MODE   = 17;
  localparam int unsigned CNT_LSB    = 18;
  localparam int unsigned CNT_W      = 10;
  localparam int unsigned DCODE_LSB  = 28;
  localparam int unsigned DCODE_W    = 4;

endpackage

// File: rtl/tfc_store.sv
module tfc_store #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] bank [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [DATA_W-1:0] ent_q;
    logic              ent_we;

    assign ent_we = wr_en && (wr_idx == PW'(i));

    always_ff @(posedge clk) begin
      if (ent_we) begin
        ent_q <= wr_data;
      end
    end

    assign bank[i] = ent_q;
  end

  assign rd_data = bank[rd_idx];

endmodule

// File: rtl/tfc_tag_ctrl.sv
module tfc_tag_ctrl
  import tfc_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned PW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_view,
  input  logic              req_wr,
  input  logic              ld_empty,
  input  logic              ld_full,
  input  logic              ld_trap,
  input  logic [DATA_W-1:0] st_rdata,
  output logic              st_we,
  output logic [PW-1:0]     st_widx,
  output logic [PW-1:0]     st_ridx,
  output logic [DATA_W-1:0] rdata_nx,
  output logic              stall_nx,
  output logic              go,
  output logic [CW-1:0]     fill_q,
  output logic              empty_q,
  output logic              full_q
);

  localparam logic [CW-1:0]      DEPTH_C = CW'(DEPTH);
  localparam logic [DCODE_W-1:0] DCODE   = DCODE_W'(PW);

  logic [PW-1:0] head_q, head_nx;
  logic [CW-1:0] fill_nx;
  logic          empty_nx, full_nx, trap_q, trap_nx;
  logic          blocking;
  logic [31:0]   tag_word;

  function automatic logic [PW-1:0] ring_idx(input logic [PW-1:0] base,
                                             input logic [CW-1:0] off);
    logic [CW-1:0] sum;
    sum = CW'(base) + off;
    return sum[PW-1:0];
  endfunction

  always_comb begin
    tag_word                          = '0;
    tag_word[BIT_EMPTY]               = empty_q;
    tag_word[BIT_FULL]                = full_q;
    tag_word[BIT_TRAP]                = trap_q;
    tag_word[BIT_MODE]                = 1'b1;
    tag_word[CNT_LSB +: CNT_W]        = CNT_W'(fill_q);
    tag_word[DCODE_LSB +: DCODE_W]    = DCODE;
  end

  assign st_ridx  = head_q;
  assign blocking = (req_view == VIEW_WAIT);

  always_comb begin
    head_nx  = head_q;
    fill_nx  = fill_q;
    empty_nx = empty_q;
    full_nx  = full_q;
    trap_nx  = trap_q;
    st_we    = 1'b0;
    st_widx  = head_q;
    rdata_nx = '0;
    stall_nx = 1'b0;
    go       = 1'b0;
    if (req_valid) begin
      unique case (req_view)
        VIEW_RAW: begin
          if (req_wr) begin
            if (fill_q != '0) begin
              st_we   = 1'b1;
              st_widx = ring_idx(head_q, fill_q - CW'(1));
            end
          end else begin
            rdata_nx = st_rdata;
          end
        end
        VIEW_TAG: begin
          if (req_wr) begin
            trap_nx  = ld_trap;
            empty_nx = ld_empty;
            full_nx  = ld_full;
            if (ld_empty) begin
              fill_nx = '0;
            end
          end else begin
            rdata_nx = DATA_W'(tag_word);
          end
        end
        default: begin
          if (!req_wr) begin
            full_nx = 1'b0;
            if (blocking && empty_q) begin
              stall_nx = 1'b1;
            end else begin
              go = 1'b1;
              if (fill_q != '0) begin
                rdata_nx = st_rdata;
                head_nx  = head_q + PW'(1);
                fill_nx  = fill_q - CW'(1);
              end
              if (fill_nx == '0) begin
                empty_nx = 1'b1;
              end
            end
          end else begin
            empty_nx = 1'b0;
            if (blocking && full_q) begin
              stall_nx = 1'b1;
            end else begin
              go = 1'b1;
              if (fill_q < DEPTH_C) begin
                st_we   = 1'b1;
                st_widx = ring_idx(head_q, fill_q);
                fill_nx = fill_q + CW'(1);
              end
              if (fill_nx == DEPTH_C) begin
                full_nx = 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      fill_q  <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
      trap_q  <= 1'b0;
    end else if (req_valid) begin
      head_q  <= head_nx;
      fill_q  <= fill_nx;
      empty_q <= empty_nx;
      full_q  <= full_nx;
      trap_q  <= trap_nx;
    end
  end

endmodule

// File: rtl/tfc_waiters.sv
module tfc_waiters #(
  parameter int unsigned NREQ = 8,
  localparam int unsigned IDW = $clog2(NREQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic            go,
  input  logic [IDW-1:0]  req_id,
  output logic [NREQ-1:0] waiter_q,
  output logic            wake_valid,
  output logic [NREQ-1:0] wake_mask
);

  logic [NREQ-1:0] waiter_nx, wmask_nx;
  logic            wake_nx;

  always_comb begin
    waiter_nx = waiter_q;
    wake_nx   = 1'b0;
    wmask_nx  = '0;
    if (stall) begin
      waiter_nx = waiter_q | (NREQ'(1) << req_id);
    end else if (go && (waiter_q != '0)) begin
      wake_nx   = 1'b1;
      wmask_nx  = waiter_q;
      waiter_nx = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiter_q   <= '0;
      wake_valid <= 1'b0;
      wake_mask  <= '0;
    end else begin
      waiter_q   <= waiter_nx;
      wake_valid <= wake_nx;
      wake_mask  <= wmask_nx;
    end
  end

endmodule

// File: rtl/tagged_fifo_cell.sv
module tagged_fifo_cell
  import tfc_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NREQ   = 8,
  localparam int unsigned PW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH) + 1,
  localparam int unsigned IDW   = $clog2(NREQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_view,
  input  logic              req_wr,
  input  logic [IDW-1:0]    req_id,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic              resp_stall,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              wake_valid,
  output logic [NREQ-1:0]   wake_mask
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              st_we;
  logic [PW-1:0]     st_widx, st_ridx;
  logic [DATA_W-1:0] st_rdata, rdata_nx;
  logic              stall_nx, go;
  logic [CW-1:0]     fill_cnt;
  logic              tag_e, tag_f;
  logic [NREQ-1:0]   waiter_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  tfc_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .wr_en   (st_we),
    .wr_idx  (st_widx),
    .wr_data (req_wdata),
    .rd_idx  (st_ridx),
    .rd_data (st_rdata)
  );

  tfc_tag_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_tag (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_view  (req_view),
    .req_wr    (req_wr),
    .ld_empty  (req_wdata[BIT_EMPTY]),
    .ld_full   (req_wdata[BIT_FULL]),
    .ld_trap   (req_wdata[BIT_TRAP]),
    .st_rdata  (st_rdata),
    .st_we     (st_we),
    .st_widx   (st_widx),
    .st_ridx   (st_ridx),
    .rdata_nx  (rdata_nx),
    .stall_nx  (stall_nx),
    .go        (go),
    .fill_q    (fill_cnt),
    .empty_q   (tag_e),
    .full_q    (tag_f)
  );

  tfc_waiters #(.NREQ(NREQ)) u_wait (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .stall      (stall_nx),
    .go         (go),
    .req_id     (req_id),
    .waiter_q   (waiter_q),
    .wake_valid (wake_valid),
    .wake_mask  (wake_mask)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      resp_valid <= 1'b0;
      resp_stall <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_stall <= stall_nx;
      resp_rdata <= rdata_nx;
    end
  end

endmodule

// File: rtl/tfc_checker.sv
module tfc_checker #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned NREQ   = 8,
  localparam int unsigned CW    = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [1:0]        req_view,
  input logic              req_wr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              resp_valid,
  input logic              resp_stall,
  input logic              wake_valid,
  input logic [NREQ-1:0]   wake_mask,
  input logic [CW-1:0]     fill,
  input logic              empty_flag,
  input logic              full_flag,
  input logic [NREQ-1:0]   waiters
);

  assert_resp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  assert_no_spurious_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  assert_stall_only_waiting_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_stall |-> (resp_valid && $past(req_view) == 2'd2));

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  assert_wake_with_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> (resp_valid && wake_mask != '0 && waiters == '0));

  assert_empty_zeroes_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_view == 2'd1 && req_wr && req_wdata[0]) |=> (fill == '0 && empty_flag));

  assert_read_clears_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_view[1] && !req_wr) |=> !full_flag);

  assert_write_clears_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_view[1] && req_wr) |=> !empty_flag);

endmodule

bind tagged_fifo_cell tfc_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W), .NREQ(NREQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_view   (req_view),
  .req_wr     (req_wr),
  .req_wdata  (req_wdata),
  .resp_valid (resp_valid),
  .resp_stall (resp_stall),
  .wake_valid (wake_valid),
  .wake_mask  (wake_mask),
  .fill       (fill_cnt),
  .empty_flag (tag_e),
  .full_flag  (tag_f),
  .waiters    (waiter_q)
);

// File: tb/tagged_fifo_cell_test.sv
`timescale 1ns/1ps
module tagged_fifo_cell_test;

  localparam int D = 8;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_view;
  logic        req_wr;
  logic [2:0]  req_id;
  logic [63:0] req_wdata;
  logic        resp_valid;
  logic        resp_stall;
  logic [63:0] resp_rdata;
  logic        wake_valid;
  logic [7:0]  wake_mask;

  tagged_fifo_cell uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_view   (req_view),
    .req_wr     (req_wr),
    .req_id     (req_id),
    .req_wdata  (req_wdata),
    .resp_valid (resp_valid),
    .resp_stall (resp_stall),
    .resp_rdata (resp_rdata),
    .wake_valid (wake_valid),
    .wake_mask  (wake_mask)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic        stall;
    logic [63:0] data;
    logic        wv;
    logic [7:0]  wm;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  // bench model of the cell
  logic [63:0] m_data [D];
  int          m_ptr, m_cnt;
  bit          m_e, m_f, m_t;
  logic [7:0]  m_mask;

  function automatic logic [63:0] tag_word();
    return {32'h0, 4'd3, 10'(m_cnt), 1'b1, m_t, 14'h0, m_f, m_e};
  endfunction

  task automatic op(input logic [1:0] view, input bit wr, input logic [63:0] d,
                    input logic [2:0] id, input string rq);
    exp_t x;
    bit   blk;
    x.stall = 0; x.data = '0; x.wv = 0; x.wm = '0; x.req = rq;
    @(negedge clk);
    req_valid = 1'b1; req_view = view; req_wr = wr; req_wdata = d; req_id = id;
    blk = (view == 2'd2);
    case (view)
      2'd0: begin
        if (wr) begin
          if (m_cnt > 0) m_data[(m_ptr + m_cnt - 1) % D] = d;
        end else x.data = m_data[m_ptr];
      end
      2'd1: begin
        if (wr) begin
          m_t = d[16]; m_e = d[0]; m_f = d[1];
          if (m_e) m_cnt = 0;
        end else x.data = tag_word();
      end
      default: begin
        if (!wr) begin
          m_f = 0;
          if (blk && m_e) x.stall = 1;
          else begin
            if (m_cnt > 0) begin
              x.data = m_data[m_ptr]; m_ptr = (m_ptr + 1) % D; m_cnt--;
            end
            if (m_cnt == 0) m_e = 1;
          end
        end else begin
          m_e = 0;
          if (blk && m_f) x.stall = 1;
          else begin
            if (m_cnt < D) begin
              m_data[(m_ptr + m_cnt) % D] = d; m_cnt++;
            end
            if (m_cnt == D) m_f = 1;
          end
        end
        if (x.stall) m_mask = m_mask | (8'd1 << id);
        else if (m_mask != 0) begin
          x.wv = 1; x.wm = m_mask; m_mask = '0;
        end
      end
    endcase
    exp_q.push_back(x);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && resp_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R10 unexpected response: actual resp_valid=1 expected 0");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (resp_stall !== e.stall || resp_rdata !== e.data ||
              wake_valid !== e.wv || wake_mask !== e.wm) begin
            fails++;
            $display("FAIL %s actual stall=%0b data=%h wake=%0b/%h expected stall=%0b data=%h wake=%0b/%h",
                     e.req, resp_stall, resp_rdata, wake_valid, wake_mask,
                     e.stall, e.data, e.wv, e.wm);
          end
        end
      end else if (rst_n && wake_valid) begin
        checks++; fails++;
        $display("FAIL R8 wake without response: actual wake_valid=1 expected 0");
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog expired: actual pending=%0d expected 0", exp_q.size());
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_view = '0; req_wr = 1'b0;
    req_id = '0; req_wdata = '0;
    m_ptr = 0; m_cnt = 0; m_e = 1; m_f = 0; m_t = 0; m_mask = '0;
    for (int i = 0; i < D; i++) m_data[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (resp_valid !== 1'b0 || wake_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 outputs after reset: actual resp=%0b wake=%0b expected 0 0",
               resp_valid, wake_valid);
    end

    op(2'd1, 0, 64'h0, 3'd0, "R1");                       // reset tag word
    op(2'd3, 0, 64'h0, 3'd0, "R5");                       // non-waiting pop of empty
    op(2'd2, 0, 64'h0, 3'd2, "R4");                       // waiting pop stalls
    op(2'd3, 1, 64'hA0A0_0000_0000_0001, 3'd0, "R8");     // push wakes id 2
    op(2'd2, 1, 64'hB0B0_0000_0000_0002, 3'd1, "R7");
    op(2'd2, 1, 64'hC0C0_0000_0000_0003, 3'd1, "R7");
    op(2'd1, 0, 64'h0, 3'd0, "R2");                       // count 3
    op(2'd0, 0, 64'h0, 3'd0, "R9");                       // raw head read
    op(2'd1, 0, 64'h0, 3'd0, "R9");                       // tag unchanged
    op(2'd0, 1, 64'hEEEE_0000_0000_00EE, 3'd0, "R9");     // patch newest
    op(2'd2, 0, 64'h0, 3'd0, "R5");
    op(2'd3, 0, 64'h0, 3'd0, "R5");
    op(2'd2, 0, 64'h0, 3'd0, "R9");                       // patched value
    op(2'd1, 0, 64'h0, 3'd0, "R5");                       // empty again
    op(2'd2, 0, 64'h0, 3'd6, "R4");
    op(2'd2, 0, 64'h0, 3'd7, "R4");
    op(2'd3, 1, 64'hD0D0_0000_0000_0000, 3'd0, "R8");     // wakes 6 and 7
    op(2'd3, 0, 64'h0, 3'd0, "R5");
    for (int i = 0; i < D; i++) op(2'd2, 1, 64'h1000 + 64'(i), 3'd0, "R7");
    op(2'd1, 0, 64'h0, 3'd0, "R7");                       // full, count 8
    op(2'd2, 1, 64'h5555, 3'd5, "R6");                    // waiting push stalls
    op(2'd3, 1, 64'h6666, 3'd0, "R7");                    // dropped, wakes 5
    op(2'd1, 0, 64'h0, 3'd0, "R7");
    for (int i = 0; i < D; i++) op((i % 2 == 0) ? 2'd2 : 2'd3, 0, 64'h0, 3'd0, "R5");
    op(2'd1, 0, 64'h0, 3'd0, "R5");
    op(2'd1, 1, 64'h0001_0002, 3'd0, "R3");               // trap=1 full=1 empty=0
    op(2'd1, 0, 64'h0, 3'd0, "R3");
    op(2'd3, 1, 64'h7777, 3'd0, "R7");
    op(2'd3, 1, 64'h8888, 3'd0, "R7");
    op(2'd3, 0, 64'h0, 3'd0, "R4");                       // pop clears full
    op(2'd1, 0, 64'h0, 3'd0, "R4");
    op(2'd1, 1, 64'h0000_0001, 3'd0, "R3");               // empty=1 zeroes count
    op(2'd1, 0, 64'h0, 3'd0, "R3");
    op(2'd0, 1, 64'hDEAD, 3'd0, "R9");                    // ignored, count 0
    op(2'd1, 0, 64'h0, 3'd0, "R9");
    op(2'd0, 0, 64'h0, 3'd0, "R9");
    op(2'd1, 1, 64'h0000_0003, 3'd0, "R3");               // empty=1 full=1
    op(2'd2, 1, 64'h9999, 3'd3, "R6");                    // stalls, clears empty
    op(2'd1, 0, 64'h0, 3'd0, "R6");
    op(2'd3, 0, 64'h0, 3'd0, "R8");                       // returns 0, wakes 3
    op(2'd1, 0, 64'h0, 3'd0, "R5");
    idle();
    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10 missing responses: actual pending=%0d expected 0", exp_q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule